// File: doc/BRIEF.md
# Virtual Channel Mapping Programmer

This block sets up how a link's eight traffic classes are spread over four virtual channels: the default channel, a second general channel, a private channel and a management channel. On a start request it captures a per-channel enable, a 3-bit channel id and an 8-bit traffic-class bitmap. It then checks that the enabled bitmaps divide the eight classes among themselves with no gaps and no overlaps. If they do, it encodes one 32-bit control word per channel and writes the words out through a simple register-write master. It also writes the extended channel count, then polls each channel's 16-bit status register until negotiation with the far end has finished.

A faulty mapping ends the run at once, before any write or read, with a mapping error. A channel whose negotiation never completes ends the run with a timeout error that names the channel. Both ends of a link must be given the same four words. The block produces one fixed word set per configuration, so one configuration can be used to drive both ends.

States and transitions: `ST_IDLE` goes to `ST_CHECK` on start. `ST_CHECK` goes to `ST_WRITE` when the map is valid and to `ST_FINISH` when it is not. `ST_WRITE` stays for four cycles, then moves to `ST_EVC`. `ST_EVC` goes to `ST_POLL`. `ST_POLL` stays until all four channels report no pending negotiation, or until a wait times out, and then goes to `ST_FINISH`. `ST_FINISH` goes back to `ST_IDLE`.

Top module: `vc_map_prog`

## Requirements
- R1: After reset, wr_en, rd_en, busy, done, fail_map, fail_tmo and fail_chan are all 0.
- R2: A control word holds the channel enable in bit 31, the channel id in bits 26:24 and the traffic-class bitmap in bits 7:0. Every other bit is 0.
- R3: With a valid map, the four control words are written in consecutive cycles, in channel order 0 (default), 1, 2 (private), 3 (management). Word n goes to CTL_BASE + n*CTL_STRIDE.
- R4: The write after the four control words goes to EVC_ADDR. Its data is 1 when channel 1 is enabled and 0 otherwise.
- R5: The map is valid only when the bitmaps of the enabled channels are pairwise disjoint and together cover all eight classes. A disabled channel's bitmap is left out of this test. An invalid map sets fail_map and finishes with no register write and no status read.
- R6: After the writes, the block reads status register CTL_BASE + n*CTL_STRIDE + STS_OFS for channels in order 0, 1, 2, 3. It moves to the next channel only after reading bit 1 (pending) as 0.
- R7: If a channel's pending bit is still 1 on TIMEOUT consecutive reads, the block sets fail_tmo, sets fail_chan to that channel's index and finishes. It makes no read of any later channel.
- R8: done is a single-cycle pulse at the end of each run. busy is high from the cycle after start is accepted through the done cycle. The fail flags hold their value until the next start is accepted.
- R9: A start or a configuration change while busy has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (accepted only when idle) |
| ch_en | input | 4 | Per-channel enable, bit n for channel n |
| ch_id | input | 12 | Per-channel 3-bit id, channel n in bits 3n+2:3n |
| ch_map | input | 32 | Per-channel traffic-class bitmap, channel n in bits 8n+7:8n |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | 32 | Register write data |
| rd_en | output | 1 | Status read strobe |
| rd_addr | output | ADDR_W | Status read address |
| rd_data | input | 16 | Status read data, valid in the cycle of rd_en |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail_map | output | 1 | Last run rejected the mapping |
| fail_tmo | output | 1 | Last run timed out on a negotiation wait |
| fail_chan | output | 2 | Channel index of the timeout |

## Verification
The checks use the fixed default map (classes 0, 3, 4, 5, 6 on channel 0; 1 on channel 1; 2 on the private channel; 7 on management). They also use random partitions of the eight classes, some with empty but enabled channels and some with channel 1 disabled. Together these separate field placement from evaluation order in the word encoding and in the extended-count value. Two directed broken maps are applied: one with a shared class and one with a missing class. They show that overlap and gaps are both caught before any bus traffic. A far-end model with random negotiation delays confirms that polling follows channel order and waits for the pending bit to clear. A channel that is held pending forever checks the exact timeout length and the reported channel index. A start pulse and a changed configuration in the middle of a run check that the run in progress is left alone.

// File: rtl/vc_map_pkg.sv
package vc_map_pkg;
    localparam int NCH  = 4;
    localparam int TC_W = 8;
    localparam int ID_W = 3;
    localparam int IDX_W = $clog2(NCH);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRITE,
        ST_EVC,
        ST_POLL,
        ST_FINISH
    } vmp_state_t;
endpackage

// File: rtl/vc_word_enc.sv
module vc_word_enc
    import vc_map_pkg::*;
(
    input  logic            en,
    input  logic [ID_W-1:0] id,
    input  logic [TC_W-1:0] tcmap,
    output logic [31:0]     word
);
    // enable at 31, id from 24, class bitmap in the low byte
    assign word = {en, {(7 - ID_W){1'b0}}, id, {(24 - TC_W){1'b0}}, tcmap};
endmodule

// File: rtl/vc_partition_chk.sv
module vc_partition_chk
    import vc_map_pkg::*;
(
    input  logic [NCH-1:0]      en,
    input  logic [NCH*TC_W-1:0] maps,
    output logic                ok
);
    logic [TC_W-1:0] covered;
    logic            clash;

    always_comb begin
        covered = '0;
        clash   = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (en[c]) begin
                clash   = clash | (|(covered & maps[c*TC_W +: TC_W]));
                covered = covered | maps[c*TC_W +: TC_W];
            end
        end
        ok = !clash && (&covered);
    end
endmodule

// File: rtl/vc_wait_timer.sv
module vc_wait_timer #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (tick && !expired) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LAST);
endmodule

// File: rtl/vc_map_prog.sv
module vc_map_prog
    import vc_map_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int unsigned CTL_BASE   = 'h0100,
    parameter int unsigned CTL_STRIDE = 'h0010,
    parameter int unsigned STS_OFS    = 'h0006,
    parameter int unsigned EVC_ADDR   = 'h0080,
    parameter int unsigned TIMEOUT    = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        ch_en,
    input  logic [11:0]       ch_id,
    input  logic [31:0]       ch_map,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [15:0]       rd_data,
    output logic              busy,
    output logic              done,
    output logic              fail_map,
    output logic              fail_tmo,
    output logic [1:0]        fail_chan
);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(CTL_BASE);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(CTL_STRIDE);
    localparam logic [ADDR_W-1:0] STS_A    = ADDR_W'(CTL_BASE + STS_OFS);
    localparam logic [ADDR_W-1:0] EVC_A    = ADDR_W'(EVC_ADDR);
    localparam int PEND_BIT = 1;

    vmp_state_t state, state_nx;

    logic [NCH-1:0]      en_q;
    logic [NCH*ID_W-1:0] id_q;
    logic [NCH*TC_W-1:0] map_q;
    logic [IDX_W-1:0]    idx;
    logic [31:0]         word_w [NCH];
    logic                map_ok;
    logic                tmo_hit;
    logic                pending;
    logic                last_ch;

    assign pending = rd_data[PEND_BIT];
    assign last_ch = (idx == IDX_W'(NCH - 1));

    for (genvar g = 0; g < NCH; g++) begin : g_enc
        vc_word_enc u_enc (
            .en    (en_q[g]),
            .id    (id_q[g*ID_W +: ID_W]),
            .tcmap (map_q[g*TC_W +: TC_W]),
            .word  (word_w[g])
        );
    end

    vc_partition_chk u_part (
        .en   (en_q),
        .maps (map_q),
        .ok   (map_ok)
    );

    vc_wait_timer #(.LIMIT(TIMEOUT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     ((state != ST_POLL) || !pending),
        .tick    (state == ST_POLL),
        .expired (tmo_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_CHECK;
            ST_CHECK:  state_nx = map_ok ? ST_WRITE : ST_FINISH;
            ST_WRITE:  if (last_ch) state_nx = ST_EVC;
            ST_EVC:    state_nx = ST_POLL;
            ST_POLL: begin
                if (!pending) begin
                    if (last_ch) state_nx = ST_FINISH;
                end else if (tmo_hit) begin
                    state_nx = ST_FINISH;
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // captured configuration, channel index and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            id_q      <= '0;
            map_q     <= '0;
            idx       <= '0;
            fail_map  <= 1'b0;
            fail_tmo  <= 1'b0;
            fail_chan <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    en_q      <= ch_en;
                    id_q      <= ch_id;
                    map_q     <= ch_map;
                    fail_map  <= 1'b0;
                    fail_tmo  <= 1'b0;
                    fail_chan <= '0;
                end
                ST_CHECK: begin
                    idx <= '0;
                    if (!map_ok) fail_map <= 1'b1;
                end
                ST_WRITE: idx <= idx + 1'b1;
                ST_EVC:   idx <= '0;
                ST_POLL: begin
                    if (!pending) begin
                        idx <= idx + 1'b1;
                    end else if (tmo_hit) begin
                        fail_tmo  <= 1'b1;
                        fail_chan <= idx;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        rd_en   = 1'b0;
        rd_addr = '0;
        unique case (state)
            ST_WRITE: begin
                wr_en   = 1'b1;
                wr_addr = BASE_A + ADDR_W'(idx) * STRIDE_A;
                wr_data = word_w[idx];
            end
            ST_EVC: begin
                wr_en   = 1'b1;
                wr_addr = EVC_A;
                wr_data = {31'b0, en_q[1]};
            end
            ST_POLL: begin
                rd_en   = 1'b1;
                rd_addr = STS_A + ADDR_W'(idx) * STRIDE_A;
            end
            default: ;
        endcase
        busy = (state != ST_IDLE);
        done = (state == ST_FINISH);
    end
endmodule

// File: rtl/vc_map_prog_chk.sv
module vc_map_prog_chk #(
    parameter int          ADDR_W     = 16,
    parameter int unsigned CTL_STRIDE = 'h0010,
    parameter int unsigned EVC_ADDR   = 'h0080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              rd_en,
    input logic              busy,
    input logic              done,
    input logic              fail_map,
    input logic              fail_tmo
);
    localparam logic [ADDR_W-1:0] EVC_A    = ADDR_W'(EVC_ADDR);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(CTL_STRIDE);

    // R2
    word_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != EVC_A) |-> (wr_data[30:27] == 4'b0 && wr_data[23:8] == 16'b0));

    // R3
    write_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && wr_addr != EVC_A) |-> (wr_addr == $past(wr_addr) + STRIDE_A));

    // R3
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    // R4
    evc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == EVC_A) |-> (wr_data[31:1] == 31'b0));

    // R5
    map_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_map |-> (!wr_en && !rd_en));

    // R7
    tmo_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_tmo) |-> done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind vc_map_prog vc_map_prog_chk #(
    .ADDR_W     (ADDR_W),
    .CTL_STRIDE (CTL_STRIDE),
    .EVC_ADDR   (EVC_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .busy     (busy),
    .done     (done),
    .fail_map (fail_map),
    .fail_tmo (fail_tmo)
);

// File: tb/sim_vc_map_prog.sv
module sim_vc_map_prog;
    localparam int CLK_P  = 10;
    localparam int AW     = 16;
    localparam int BASE   = 'h0100;
    localparam int STR    = 'h0010;
    localparam int SOFS   = 'h0006;
    localparam int EVCA   = 'h0080;
    localparam int TMO    = 16;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [3:0]  ch_en = '0;
    logic [11:0] ch_id = '0;
    logic [31:0] ch_map = '0;
    logic wr_en, rd_en, busy, done, fail_map, fail_tmo;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic [15:0] rd_data;
    logic [1:0]  fail_chan;

    int n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    vc_map_prog #(.ADDR_W(AW), .CTL_BASE(BASE), .CTL_STRIDE(STR), .STS_OFS(SOFS),
                  .EVC_ADDR(EVCA), .TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_en(ch_en), .ch_id(ch_id),
        .ch_map(ch_map), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .done(done), .fail_map(fail_map), .fail_tmo(fail_tmo), .fail_chan(fail_chan));

    // far end: pending set on control-word write, cleared after a delay
    logic [3:0] pend = '0;
    int dly[4];
    int cnt[4];
    bit stuck[4];
    bit fe_clr = 0;
    always @(posedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (fe_clr) pend[c] <= 1'b0;
            else if (wr_en && int'(wr_addr) == BASE + c*STR) begin
                pend[c] <= 1'b1; cnt[c] <= dly[c];
            end else if (pend[c]) begin
                if (cnt[c] == 0) begin if (!stuck[c]) pend[c] <= 1'b0; end
                else cnt[c] <= cnt[c] - 1;
            end
        end
    end
    logic [1:0] rd_ch;
    assign rd_ch   = 2'((int'(rd_addr) - BASE - SOFS) / STR);
    assign rd_data = {14'b0, pend[rd_ch], 1'b0};

    // monitor
    bit rec = 0;
    int nwr, nseq, ndone;
    int wa[16];
    logic [31:0] wd[16];
    int rseq[16];
    int rcount[4];
    bit lastp[4];
    always @(negedge clk) if (rec) begin
        if (wr_en && nwr < 16) begin wa[nwr] = int'(wr_addr); wd[nwr] = wr_data; nwr++; end
        if (rd_en) begin
            rcount[rd_ch]++; lastp[rd_ch] = rd_data[1];
            if ((nseq == 0 || rseq[nseq-1] != int'(rd_ch)) && nseq < 16) begin
                rseq[nseq] = int'(rd_ch); nseq++;
            end
        end
        if (done) ndone++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic en, input logic [2:0] id,
                                             input logic [7:0] m);
        return (32'(en) << 31) | (32'(id) << 24) | 32'(m);
    endfunction

    function automatic bit part_ok(input logic [3:0] en, input logic [31:0] m);
        int hits[8];
        for (int t = 0; t < 8; t++) hits[t] = 0;
        for (int c = 0; c < 4; c++)
            if (en[c]) for (int t = 0; t < 8; t++) if (m[c*8+t]) hits[t]++;
        for (int t = 0; t < 8; t++) if (hits[t] != 1) return 0;
        return 1;
    endfunction

    task automatic run_case(input logic [3:0] en, input logic [11:0] id,
                            input logic [31:0] m, input int stuck_ch, input bit poke);
        bit good;
        int lim;
        good = part_ok(en, m);
        for (int c = 0; c < 4; c++) begin
            stuck[c] = (c == stuck_ch); dly[c] = int'($urandom % 10); rcount[c] = 0; lastp[c] = 0;
        end
        fe_clr = 1; @(negedge clk); fe_clr = 0;
        nwr = 0; nseq = 0; ndone = 0; rec = 1;
        ch_en = en; ch_id = id; ch_map = m; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        lim = 0;
        while (!done && lim < 400) begin
            @(negedge clk); lim++;
            if (poke && lim == 3) begin ch_en = ~en; ch_map = ~m; ch_id = ~id; start = 1'b1; end
            if (poke && lim == 4) start = 1'b0;
        end
        chk(done == 1'b1, "R8", "done reached", done, 1);
        repeat (4) @(negedge clk);
        rec = 0;
        chk(ndone == 1, "R8", "done pulses", ndone, 1);
        chk(busy == 1'b0, "R8", "idle after done", busy, 0);
        if (!good) begin
            chk(fail_map == 1'b1, "R5", "fail_map", fail_map, 1);
            chk(nwr == 0 && nseq == 0, "R5", "bus activity", nwr + nseq, 0);
        end else if (stuck_ch >= 0) begin
            chk(fail_tmo && fail_chan == 2'(stuck_ch), "R7", "timeout chan",
                {fail_tmo, fail_chan}, {1'b1, 2'(stuck_ch)});
            chk(rcount[stuck_ch] == TMO, "R7", "reads of stuck chan", rcount[stuck_ch], TMO);
            chk(nseq == stuck_ch + 1, "R7", "channels polled", nseq, stuck_ch + 1);
        end else begin
            chk(!fail_map && !fail_tmo, "R5", "no error", {fail_map, fail_tmo}, 0);
            chk(nwr == 5, "R3", "write count", nwr, 5);
            for (int c = 0; c < 4; c++) begin
                chk(wa[c] == BASE + c*STR, "R3", "write addr", wa[c], BASE + c*STR);
                chk(wd[c] == exp_word(en[c], id[c*3 +: 3], m[c*8 +: 8]), "R2", "word",
                    wd[c], exp_word(en[c], id[c*3 +: 3], m[c*8 +: 8]));
                chk(nseq == 4 && rseq[c] == c, "R6", "poll order", rseq[c], c);
                chk(lastp[c] == 1'b0, "R6", "left while pending", lastp[c], 0);
            end
            chk(wa[4] == EVCA && wd[4] == {31'b0, en[1]}, "R4", "ext count",
                wd[4], {31'b0, en[1]});
        end
        repeat (3) @(negedge clk);
        chk(fail_map == !good, "R8", "flag held", fail_map, !good);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] en; logic [11:0] id; logic [31:0] m;
        void'($urandom(32'd7421));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({wr_en, rd_en, busy, done, fail_map, fail_tmo, fail_chan} == '0, "R1",
            "reset outputs", {wr_en, rd_en, busy, done, fail_map, fail_tmo, fail_chan}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // default map: ch0 {0,3,4,5,6}, ch1 {1}, ch2 {2}, ch3 {7}
        run_case(4'hF, {3'd7, 3'd2, 3'd1, 3'd0}, {8'h80, 8'h04, 8'h02, 8'h79}, -1, 0);
        // R5 overlap: class 2 on ch1 and ch2
        run_case(4'hF, {3'd7, 3'd2, 3'd1, 3'd0}, {8'h80, 8'h04, 8'h06, 8'h79}, -1, 0);
        // R5 gap: class 7 uncovered
        run_case(4'hF, {3'd7, 3'd2, 3'd1, 3'd0}, {8'h00, 8'h04, 8'h02, 8'h79}, -1, 0);
        // R5 disabled channel map ignored
        run_case(4'b0111, {3'd7, 3'd2, 3'd1, 3'd0}, {8'hFF, 8'h04, 8'h02, 8'hF9}, -1, 0);
        // R7 timeout on private channel
        run_case(4'hF, {3'd7, 3'd2, 3'd1, 3'd0}, {8'h80, 8'h04, 8'h02, 8'h79}, 2, 0);
        // R9 start and config change while busy
        run_case(4'hF, {3'd7, 3'd2, 3'd1, 3'd0}, {8'h80, 8'h04, 8'h02, 8'h79}, -1, 1);
        // random partitions (R2, R3, R4, R6)
        for (int k = 0; k < 10; k++) begin
            m = '0;
            for (int t = 0; t < 8; t++) begin
                int c = int'($urandom % 4);
                m[c*8 + t] = 1'b1;
            end
            for (int c = 0; c < 4; c++)
                en[c] = (m[c*8 +: 8] != 0) ? 1'b1 : 1'($urandom % 2);
            id = 12'($urandom);
            run_case(en, id, m, -1, 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule